// File: doc/BRIEF.md
# Descriptor Chain Sequencer

This block walks a linked list of transfer descriptors kept in memory and hands each one, as a single segment, to an external data mover. A descriptor is 32 bytes and aligned to 32 bytes. It holds four 64-bit words: a byte count in the low 32 bits of word 0, the source address in word 1, the destination address in word 2 and the next-link word in word 3. The sequencer reads the four words in that order over a simple read port that allows one request in flight. It then drives the mover with a start/done handshake and follows the link to the next descriptor.

Two flags ride in the low bits of the next-link word. Bit 0 marks the last descriptor of the list, and bit 3 requests an end-of-segment event when that descriptor completes. All bits below bit 5 are dropped when the link is used as an address. A descriptor whose byte count is zero is treated as a deliberate programming error. Software can queue one as a marker that the chain has reached a point, because the walk stops there and flags it.

Software controls the block through three registers. The descriptor pointer register holds the current descriptor address. The mode register holds the start, abort and interrupt-enable bits. The status register reports busy, halted and four event bits that are cleared by writing ones to them.

Top module: `desc_chain_seq`

## Requirements
- R1: After reset, status, mode, descriptor pointer and remaining count read zero; irq, mem_rd_req and mv_start are low; idle is high.
- R2: A mode write (wr_sel=0) with start (bit 0) set and abort (bit 1) clear, issued while not busy, not halted and with a non-zero pointer, sets busy (status bit 0). The block then reads the descriptor words at pointer+0, +8, +16 and +24 in that order, and holds mem_rd_req until each read returns.
- R3: For each descriptor with a non-zero count, mv_start is held with mv_src, mv_dst and mv_len equal to words 1, 2 and the count, until mv_done.
- R4: When a segment completes and bit 0 of its link is clear, the next fetch starts at the link with bits 4..0 cleared.
- R5: When a segment completes and bit 0 of its link is set, the walk stops, busy clears, end-of-links (status bit 5) sets and the pointer keeps that descriptor's address.
- R6: A completed segment whose link has bit 3 set sets end-of-segment (status bit 4). A completed segment with bit 3 clear leaves status bit 4 unchanged.
- R7: A descriptor with a zero count sets programming-error (status bit 3), starts no segment, leaves the remaining count at zero and ends the walk with the pointer at that descriptor.
- R8: A read returned with mem_rd_err sets transfer-error (status bit 2) and halted (status bit 1), and clears busy.
- R9: A mode write with abort set stops any walk and sets halted. While halted no start takes effect. A mode write with start and abort both clear releases halted. idle equals not-busy or halted.
- R10: Writing the status register (wr_sel=2) clears each of bits 5..2 that is written as one and leaves the others. Bits 1..0 ignore writes.
- R11: irq is high when error enable (mode bit 2) is set and bit 2 or 3 of status is set, or when mode bit 3 is set and status bit 4 is set, or when mode bit 4 is set and status bit 5 is set.
- R12: Pointer writes (wr_sel=1) drop bits 4..0 and are ignored while busy. A start with a zero pointer does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 pointer, 2 status |
| wr_data | input | AW | Register write data |
| cur_desc | output | AW | Current descriptor pointer |
| mode_q | output | 5 | Mode register: start, abort, error/segment/links enables |
| status | output | 6 | {eol, eos, prog_err, xfer_err, halted, busy} |
| byte_rem | output | CW | Remaining byte count of the segment in progress |
| irq | output | 1 | Interrupt request |
| idle | output | 1 | Not busy or halted |
| mem_rd_req | output | 1 | Descriptor read request, held until returned |
| mem_rd_addr | output | AW | Descriptor word address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | DW | Read data |
| mem_rd_err | input | 1 | Read returned an error |
| mv_start | output | 1 | Segment request to the mover, held until done |
| mv_src | output | AW | Segment source address |
| mv_dst | output | AW | Segment destination address |
| mv_len | output | CW | Segment byte count |
| mv_done | input | 1 | Mover completed the segment |

## Verification
The assertions check several properties on every cycle. A segment request stays steady until the mover answers, and never carries a zero length. Halting silences both the read port and the mover. Traffic only happens while busy. A read error lands as halted plus transfer-error. irq never rises without a pending event. The pointer never moves while busy, except on a segment completion. The bench's sweeps show what no single-cycle property can see: the order of fetch addresses, link masking and chain following across chains of one to four descriptors with every end-of-segment pattern, the final pointer and event bits, the zero-count stop, the write-one-to-clear masks and the interrupt enable table.

// File: rtl/desc_chain_seq.sv
module desc_chain_seq #(
  parameter int AW = 64,
  parameter int CW = 32,
  parameter int DW = 64,
  parameter int LINK_ALIGN = 5
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] cur_desc,
  output logic [4:0]    mode_q,
  output logic [5:0]    status,
  output logic [CW-1:0] byte_rem,
  output logic          irq,
  output logic          idle,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data,
  input  logic          mem_rd_err,
  output logic          mv_start,
  output logic [AW-1:0] mv_src,
  output logic [AW-1:0] mv_dst,
  output logic [CW-1:0] mv_len,
  input  logic          mv_done
);
  localparam int SH = $clog2(DW / 8);
  localparam logic [AW-1:0] LMASK = ~((AW'(1) << LINK_ALIGN) - AW'(1));
  localparam logic [1:0] SEL_MODE = 2'd0, SEL_CDAR = 2'd1, SEL_STAT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC, S_MOVE} st_t;

  st_t           st;
  logic [1:0]    widx;
  logic [AW-1:0] cdar, src_r, dst_r, lnk_r;
  logic [CW-1:0] cnt_r, rem_r;
  logic [4:0]    mode_r;
  logic          halted;
  logic [3:0]    ev, ev_set;

  wire mode_wr   = wr_en && wr_sel == SEL_MODE;
  wire abort_wr  = mode_wr && wr_data[1];
  wire go        = mode_wr && wr_data[0] && !wr_data[1] && st == S_IDLE && !halted && cdar != '0;
  wire fetch_err = st == S_FETCH && mem_rd_valid && mem_rd_err;
  wire seg_done  = st == S_MOVE && mv_done;
  wire busy      = st != S_IDLE;

  assign ev_set = abort_wr ? 4'b0000
                : {seg_done && lnk_r[0], seg_done && lnk_r[3], st == S_EXEC && cnt_r == '0, fetch_err};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      widx   <= '0;
      cdar   <= '0;
      src_r  <= '0;
      dst_r  <= '0;
      lnk_r  <= '0;
      cnt_r  <= '0;
      rem_r  <= '0;
      mode_r <= '0;
      halted <= 1'b0;
      ev     <= '0;
    end else begin
      if (mode_wr) mode_r <= wr_data[4:0];

      if (wr_en && wr_sel == SEL_STAT) ev <= (ev & ~wr_data[5:2]) | ev_set;
      else                             ev <= ev | ev_set;

      if (abort_wr || fetch_err)                halted <= 1'b1;
      else if (mode_wr && wr_data[1:0] == 2'b00) halted <= 1'b0;

      if (wr_en && wr_sel == SEL_CDAR && st == S_IDLE) cdar <= wr_data & LMASK;

      if (abort_wr) begin
        st <= S_IDLE;
      end else begin
        unique case (st)
          S_IDLE: if (go) begin
            st   <= S_FETCH;
            widx <= '0;
          end
          S_FETCH: if (mem_rd_valid) begin
            if (mem_rd_err) begin
              st <= S_IDLE;
            end else begin
              unique case (widx)
                2'd0: cnt_r <= mem_rd_data[CW-1:0];
                2'd1: src_r <= mem_rd_data[AW-1:0];
                2'd2: dst_r <= mem_rd_data[AW-1:0];
                2'd3: lnk_r <= mem_rd_data[AW-1:0];
              endcase
              if (widx == 2'd3) st <= S_EXEC;
              widx <= widx + 2'd1;
            end
          end
          S_EXEC: begin
            rem_r <= cnt_r;
            st    <= (cnt_r == '0) ? S_IDLE : S_MOVE;
          end
          S_MOVE: if (mv_done) begin
            rem_r <= '0;
            if (lnk_r[0]) begin
              st <= S_IDLE;
            end else begin
              cdar <= lnk_r & LMASK;
              widx <= '0;
              st   <= S_FETCH;
            end
          end
        endcase
      end
    end
  end

  assign mem_rd_req  = st == S_FETCH;
  assign mem_rd_addr = cdar + (AW'(widx) << SH);
  assign mv_start    = st == S_MOVE;
  assign mv_src      = src_r;
  assign mv_dst      = dst_r;
  assign mv_len      = cnt_r;
  assign cur_desc    = cdar;
  assign mode_q      = mode_r;
  assign byte_rem    = rem_r;
  assign status      = {ev, halted, busy};
  assign idle        = !busy || halted;
  assign irq         = (mode_r[2] && (ev[0] || ev[1])) || (mode_r[3] && ev[2]) || (mode_r[4] && ev[3]);
endmodule

// File: rtl/desc_chain_seq_chk.sv
module desc_chain_seq_chk #(
  parameter int AW = 64,
  parameter int CW = 32
)(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [AW-1:0] wr_data,
  input logic [AW-1:0] cur_desc,
  input logic [5:0]    status,
  input logic [CW-1:0] byte_rem,
  input logic          irq,
  input logic          mem_rd_req,
  input logic          mem_rd_valid,
  input logic          mem_rd_err,
  input logic          mv_start,
  input logic [AW-1:0] mv_src,
  input logic [AW-1:0] mv_dst,
  input logic [CW-1:0] mv_len,
  input logic          mv_done
);
  wire abort_wr = wr_en && wr_sel == 2'd0 && wr_data[1];

  // R3
  mv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_start && !mv_done && !abort_wr) |=> (mv_start && $stable(mv_src) && $stable(mv_dst) && $stable(mv_len)));

  // R7
  mv_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |-> (mv_len != '0 && byte_rem == mv_len));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> (!status[0] && !mv_start && !mem_rd_req));

  // R2
  traffic_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mv_start) |-> status[0]);

  // R8
  fetch_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_valid && mem_rd_err && !abort_wr) |=> (status[2] && status[1] && !status[0]));

  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status[5:2] != 4'b0000));

  // R12
  ptr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !(mv_start && mv_done)) |=> $stable(cur_desc));
endmodule

bind desc_chain_seq desc_chain_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cur_desc(cur_desc), .status(status), .byte_rem(byte_rem), .irq(irq),
  .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid), .mem_rd_err(mem_rd_err),
  .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len), .mv_done(mv_done)
);

// File: tb/desc_chain_seq_bench.sv
module desc_chain_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] cur_desc;
  logic [4:0]  mode_q;
  logic [5:0]  status;
  logic [31:0] byte_rem;
  logic        irq, idle;
  logic        mem_rd_req;
  logic [63:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [63:0] mem_rd_data;
  logic        mem_rd_err;
  logic        mv_start;
  logic [63:0] mv_src, mv_dst;
  logic [31:0] mv_len;
  logic        mv_done;

  desc_chain_seq u_desc_chain_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cur_desc(cur_desc), .mode_q(mode_q), .status(status), .byte_rem(byte_rem),
    .irq(irq), .idle(idle),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
    .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len), .mv_done(mv_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] mem [0:255];
  logic [63:0] err_addr = 64'hFFFF_FFFF;
  int          lat, mvc;
  int          mvn = 0, fn = 0;
  logic [63:0] log_src [0:511];
  logic [63:0] log_dst [0:511];
  logic [31:0] log_len [0:511];
  logic [63:0] flog    [0:1023];
  int          checks = 0, errors = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rd_valid <= 1'b0; mem_rd_err <= 1'b0; mem_rd_data <= '0; lat <= 0;
    end else begin
      mem_rd_valid <= 1'b0;
      mem_rd_err   <= 1'b0;
      if (mem_rd_req && !mem_rd_valid) begin
        if (lat == 2) begin
          mem_rd_valid <= 1'b1;
          mem_rd_data  <= mem[mem_rd_addr[10:3]];
          mem_rd_err   <= (mem_rd_addr == err_addr);
          lat <= 0;
        end else lat <= lat + 1;
      end else lat <= 0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mv_done <= 1'b0; mvc <= 0;
    end else begin
      mv_done <= 1'b0;
      if (mv_start && !mv_done) begin
        if (mvc == 2) begin mv_done <= 1'b1; mvc <= 0; end
        else mvc <= mvc + 1;
      end else mvc <= 0;
    end
  end

  always @(posedge clk) begin
    if (rst_n && mv_start && mv_done) begin
      log_src[mvn % 512] <= mv_src;
      log_dst[mvn % 512] <= mv_dst;
      log_len[mvn % 512] <= mv_len;
      mvn <= mvn + 1;
    end
    if (rst_n && mem_rd_req && mem_rd_valid && !mem_rd_err) begin
      flog[fn % 1024] <= mem_rd_addr;
      fn <= fn + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000; k++) begin
      if (!status[0]) return;
      @(negedge clk);
    end
    chk("R2 walk did not finish", 64'd1, 64'd0);
  endtask

  task automatic put_desc(input logic [63:0] a, input logic [31:0] cnt,
                          input logic [63:0] s, input logic [63:0] d, input logic [63:0] lnk);
    mem[a[10:3]]     = {32'hDEAD_0000, cnt};
    mem[a[10:3] + 1] = s;
    mem[a[10:3] + 2] = d;
    mem[a[10:3] + 3] = lnk;
  endtask

  function automatic logic [63:0] daddr(input int i);
    return 64'h100 + 64'(3 - i) * 64'h80 + 64'h20;
  endfunction

  task automatic run_chain(input int len, input int pat);
    int n0, f0;
    logic eos_exp;
    eos_exp = 1'b0;
    for (int i = 0; i < len; i++) begin
      logic [63:0] lnk;
      lnk = (i == len - 1) ? 64'h17 : (daddr(i + 1) | 64'h16);
      if (pat[i]) begin lnk = lnk | 64'h8; eos_exp = 1'b1; end
      put_desc(daddr(i), 32'(8 * (i + 1) + 1), 64'h1000_0000 + 64'(i) * 64'h100,
               64'h2000_0000 + 64'(i) * 64'h100, lnk);
    end
    wr(2'd2, 64'h3C);
    wr(2'd1, daddr(0));
    n0 = mvn; f0 = fn;
    wr(2'd0, 64'h1D);
    wait_idle();
    chk("R3 segment count", 64'(mvn - n0), 64'(len));
    for (int i = 0; i < len; i++) begin
      chk("R3 mv_src", log_src[(n0 + i) % 512], 64'h1000_0000 + 64'(i) * 64'h100);
      chk("R3 mv_dst", log_dst[(n0 + i) % 512], 64'h2000_0000 + 64'(i) * 64'h100);
      chk("R3 mv_len", 64'(log_len[(n0 + i) % 512]), 64'(8 * (i + 1) + 1));
      for (int w = 0; w < 4; w++)
        chk("R2 R4 fetch address", flog[(f0 + 4 * i + w) % 1024], daddr(i) + 64'(8 * w));
    end
    chk("R5 R6 status", 64'(status), {58'd0, 1'b1, eos_exp, 4'b0000});
    chk("R5 final pointer", cur_desc, daddr(len - 1));
    chk("R5 remaining count", 64'(byte_rem), 64'd0);
    for (int e = 0; e < 8; e++) begin
      wr(2'd0, 64'(e << 2));
      chk("R11 irq", 64'(irq), 64'(e[2] || (e[1] && eos_exp)));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", 64'(status), 64'd0);
    chk("R1 mode", 64'(mode_q), 64'd0);
    chk("R1 pointer", cur_desc, 64'd0);
    chk("R1 remaining", 64'(byte_rem), 64'd0);
    chk("R1 outputs", {60'd0, irq, idle, mem_rd_req, mv_start}, 64'b0100);

    // R12 zero pointer start and pointer alignment
    wr(2'd0, 64'h1);
    repeat (5) @(negedge clk);
    chk("R12 start with zero pointer", {62'd0, status[0], mem_rd_req}, 64'd0);
    chk("R12 no fetch", 64'(fn), 64'd0);
    wr(2'd0, 64'h0);
    wr(2'd1, 64'h1F3);
    chk("R12 pointer low bits dropped", cur_desc, 64'h1E0);

    for (int len = 1; len <= 4; len++)
      for (int pat = 0; pat < (1 << len); pat++)
        run_chain(len, pat);

    // R7 zero-count marker after a segment
    put_desc(64'h600, 32'd16, 64'h3000, 64'h4000, 64'h640 | 64'h8);
    put_desc(64'h640, 32'd0, 64'h5000, 64'h6000, 64'h1);
    wr(2'd2, 64'h3C);
    wr(2'd1, 64'h600);
    n0 = mvn;
    wr(2'd0, 64'h1);
    wait_idle();
    chk("R7 one segment only", 64'(mvn - n0), 64'd1);
    chk("R7 status pe+eos", 64'(status), 64'h18);
    chk("R7 pointer at marker", cur_desc, 64'h640);
    chk("R7 remaining zero", 64'(byte_rem), 64'd0);
    wr(2'd0, 64'h4);
    chk("R11 irq from prog error", 64'(irq), 64'd1);

    // R10 write-one-to-clear
    wr(2'd2, 64'h0);
    chk("R10 zero write keeps", 64'(status), 64'h18);
    wr(2'd2, 64'h10);
    chk("R10 clear eos only", 64'(status), 64'h08);
    wr(2'd2, 64'h3);
    chk("R10 busy/halted ignore writes", 64'(status), 64'h08);
    wr(2'd2, 64'h08);
    chk("R10 clear pe", 64'(status), 64'h00);

    // R8 fetch error
    put_desc(64'h680, 32'd20, 64'h7000, 64'h7100, 64'h6C0);
    put_desc(64'h6C0, 32'd24, 64'h7200, 64'h7300, 64'h1);
    err_addr = 64'h6D0;
    wr(2'd1, 64'h680);
    n0 = mvn;
    wr(2'd0, 64'h1);
    wait_idle();
    chk("R8 status te+halted", 64'(status), 64'h06);
    chk("R8 segments before error", 64'(mvn - n0), 64'd1);
    chk("R8 idle", 64'(idle), 64'd1);
    chk("R8 pointer", cur_desc, 64'h6C0);
    wr(2'd0, 64'h4);
    chk("R9 release halt", 64'(status[1]), 64'd0);
    chk("R11 irq from transfer error", 64'(irq), 64'd1);
    err_addr = 64'hFFFF_FFFF;
    wr(2'd2, 64'h3C);

    // R9 abort during fetch
    put_desc(64'h700, 32'd40, 64'h8000, 64'h8100, 64'h1);
    wr(2'd1, 64'h700);
    n0 = mvn;
    wr(2'd0, 64'h1);
    repeat (2) @(negedge clk);
    wr(2'd0, 64'h3);
    chk("R9 abort state", {58'd0, status[1:0], idle, mem_rd_req, mv_start, 1'b0}, 64'b101000);
    wr(2'd0, 64'h1);
    repeat (10) @(negedge clk);
    chk("R9 start blocked while halted", {62'd0, status[1:0]}, 64'b10);
    chk("R9 no segment", 64'(mvn - n0), 64'd0);
    wr(2'd0, 64'h0);
    chk("R9 halt released", 64'(status), 64'd0);

    // R12 pointer write ignored while busy
    wr(2'd0, 64'h1);
    wr(2'd1, 64'h7E0);
    wait_idle();
    chk("R12 pointer write while busy", cur_desc, 64'h700);
    chk("R3 restarted segment", 64'(mvn - n0), 64'd1);
    chk("R3 restarted length", 64'(log_len[n0 % 512]), 64'd40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule